// File: doc/BRIEF.md
# Byte Lane Alignment Unit for Loads and Stores

This unit sits between a processor core and a data memory that is one 32-bit word wide but addressed by byte. On a load it takes the low bits of the effective address and the word read from memory. It returns either the whole word or a single byte taken from the addressed lane and sign-extended to 32 bits. On a store it takes the address offset, the register value and the access size. It produces the write word and one write strobe per byte lane.

A configuration input picks how byte offsets map onto lanes. In big-endian numbering, offset 0 is the most significant lane. In little-endian numbering, offset 0 is the least significant lane. A word access must sit on a 4-byte boundary. When it does not, the unit raises a misalignment flag and suppresses every strobe. Results are registered and appear one clock after the request.

Top module: `lsu_align`

## Requirements
- R1: While reset is held, and in the first cycle after it, rspValid, misalign, byteEn, loadData and wrData are all zero.
- R2: With bigEndian=0, byte offset k selects lane k, bits 8k+7..8k. Offset 0 is bits 7..0.
- R3: With bigEndian=1, byte offset k selects lane 3-k. Offset 0 is bits 31..24.
- R4: A byte load (reqStore=0, reqByte=1) returns the selected byte in loadData bits 7..0. Bits 31..8 are copies of that byte's bit 7.
- R5: An aligned word load (reqByte=0, offset 0) returns memRdata unchanged on loadData.
- R6: A byte store returns storeData bits 7..0 copied into all four lanes of wrData. It asserts exactly one byteEn bit: bit n enables bits 8n+7..8n, and n is the lane given by R2/R3.
- R7: An aligned word store returns storeData unchanged on wrData, with byteEn = 4'b1111.
- R8: A word access with a nonzero offset raises misalign and gives byteEn = 0, loadData = 0 and wrData = 0.
- R9: Each result appears on the outputs exactly one clock after its request. After a cycle with reqValid=0, rspValid, byteEn and misalign are all zero.
- R10: A byte access at any offset never raises misalign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bigEndian | input | 1 | 1 = big-endian lane numbering, 0 = little-endian |
| reqValid | input | 1 | A request is presented this cycle |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqByte | input | 1 | 1 = byte access, 0 = word access |
| reqOffset | input | 2 | Low two bits of the effective address |
| storeData | input | 32 | Register value to be stored |
| memRdata | input | 32 | Word read from memory for a load |
| rspValid | output | 1 | Registered result is valid |
| loadData | output | 32 | Aligned and extended load result |
| wrData | output | 32 | Word to write to memory |
| byteEn | output | 4 | Write strobe per byte lane |
| misalign | output | 1 | Word access was not on a 4-byte boundary |

## Verification
The assertions assume that reqStore, reqByte, reqOffset and bigEndian are held steady for the whole clock in which reqValid is high. They also assume that memRdata is the word at the addressed location in that same cycle. The driver changes every input only at the falling edge, and it pairs each request with the memory word it chose. It also mixes idle cycles into the traffic, so the checks on what follows an idle request see real gaps rather than only back-to-back traffic.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);

  typedef struct packed {
    logic             valid;
    logic             isStore;
    logic             isByte;
    logic             misalign;
    logic [OFF_W-1:0] lane;
  } ctlStrobes_t;
endpackage

// File: rtl/lsu_align_ctrl.sv
module lsu_align_ctrl
  import lsu_align_pkg::*;
(
  input  logic             bigEndian,
  input  logic             reqValid,
  input  logic             reqStore,
  input  logic             reqByte,
  input  logic [OFF_W-1:0] reqOffset,
  output ctlStrobes_t      ctl
);
  localparam logic [OFF_W-1:0] LAST_LANE = OFF_W'(LANES - 1);

  always_comb begin
    ctl.valid    = reqValid;
    ctl.isStore  = reqStore;
    ctl.isByte   = reqByte;
    // word accesses must sit on a lane-0 boundary; bytes fit anywhere
    ctl.misalign = reqValid && !reqByte && (reqOffset != '0);
    ctl.lane     = bigEndian ? (LAST_LANE - reqOffset) : reqOffset;
  end
endmodule

// File: rtl/lsu_align_dp.sv
module lsu_align_dp
  import lsu_align_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] loadData,
  output logic [DATA_W-1:0] wrData,
  output logic [LANES-1:0]  byteEn,
  output logic              misalign
);
  logic [LANES-1:0]  laneOneHot;
  logic [7:0]        laneByte;
  logic [DATA_W-1:0] nextLoad;
  logic [DATA_W-1:0] nextWr;
  logic [LANES-1:0]  nextEn;

  for (genvar g = 0; g < LANES; g++) begin : gLaneDec
    assign laneOneHot[g] = (ctl.lane == OFF_W'(g));
  end

  assign laneByte = memRdata[ctl.lane*8 +: 8];

  always_comb begin
    nextLoad = '0;
    nextWr   = '0;
    nextEn   = '0;
    if (ctl.valid && !ctl.misalign) begin
      if (ctl.isStore) begin
        if (ctl.isByte) begin
          nextWr = {LANES{storeData[7:0]}};
          nextEn = laneOneHot;
        end else begin
          nextWr = storeData;
          nextEn = '1;
        end
      end else if (ctl.isByte) begin
        nextLoad = {{(DATA_W-8){laneByte[7]}}, laneByte};
      end else begin
        nextLoad = memRdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      loadData <= '0;
      wrData   <= '0;
      byteEn   <= '0;
      misalign <= 1'b0;
    end else begin
      rspValid <= ctl.valid;
      loadData <= nextLoad;
      wrData   <= nextWr;
      byteEn   <= nextEn;
      misalign <= ctl.misalign;
    end
  end

  // R4
  byte_sign_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.valid && !ctl.isStore && ctl.isByte |=> loadData[DATA_W-1:8] == {(DATA_W-8){loadData[7]}});

  // R6
  byte_store_one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.valid && ctl.isStore && ctl.isByte |=> $countones(byteEn) == 1);

  // R8
  misalign_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.valid && ctl.misalign |=> misalign && byteEn == '0 && loadData == '0);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.valid |=> !rspValid && byteEn == '0 && !misalign);

  // R10
  byte_never_misaligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.valid && ctl.isByte |=> rspValid && !misalign);
endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_align_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bigEndian,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic              reqByte,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] loadData,
  output logic [DATA_W-1:0] wrData,
  output logic [LANES-1:0]  byteEn,
  output logic              misalign
);
  ctlStrobes_t ctl;

  lsu_align_ctrl u_ctrl (
    .bigEndian (bigEndian),
    .reqValid  (reqValid),
    .reqStore  (reqStore),
    .reqByte   (reqByte),
    .reqOffset (reqOffset),
    .ctl       (ctl)
  );

  lsu_align_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .storeData (storeData),
    .memRdata  (memRdata),
    .rspValid  (rspValid),
    .loadData  (loadData),
    .wrData    (wrData),
    .byteEn    (byteEn),
    .misalign  (misalign)
  );
endmodule

// File: tb/lsu_align_bench.sv
module lsu_align_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        bigEndian, reqValid, reqStore, reqByte;
  logic [1:0]  reqOffset;
  logic [31:0] storeData, memRdata;
  logic        rspValid, misalign;
  logic [31:0] loadData, wrData;
  logic [3:0]  byteEn;

  typedef struct {
    logic [31:0] ld;
    logic [31:0] wd;
    logic [3:0]  en;
    logic        mis;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  int   nRun  = 0;
  int   nFail = 0;
  bit   done  = 0;

  always #10 clk = ~clk;

  lsu_align u_lsu_align (
    .clk(clk), .rstN(rstN), .bigEndian(bigEndian), .reqValid(reqValid),
    .reqStore(reqStore), .reqByte(reqByte), .reqOffset(reqOffset),
    .storeData(storeData), .memRdata(memRdata), .rspValid(rspValid),
    .loadData(loadData), .wrData(wrData), .byteEn(byteEn), .misalign(misalign)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // model built from the requirements: lane index then shift
  task automatic drive(bit be, bit st, bit by, logic [1:0] off,
                       logic [31:0] sd, logic [31:0] rd, string tag);
    exp_t e;
    int lane;
    logic [7:0] b;
    @(negedge clk);
    bigEndian = be; reqValid = 1'b1; reqStore = st; reqByte = by;
    reqOffset = off; storeData = sd; memRdata = rd;
    lane = be ? (3 - int'(off)) : int'(off);
    e.ld = 32'h0; e.wd = 32'h0; e.en = 4'h0; e.mis = 1'b0; e.tag = tag;
    if (!by && off != 2'd0) begin
      e.mis = 1'b1;
    end else if (st) begin
      if (by) begin
        e.wd = {sd[7:0], sd[7:0], sd[7:0], sd[7:0]};
        e.en = 4'b0001 << lane;
      end else begin
        e.wd = sd;
        e.en = 4'hF;
      end
    end else if (by) begin
      b = 8'(rd >> (8 * lane));
      e.ld = b[7] ? {24'hFFFFFF, b} : {24'h0, b};
    end else begin
      e.ld = rd;
    end
    expQ.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // monitor: compares one registered result per cycle
  always @(negedge clk) begin
    if (rstN === 1'b1 && !done) begin
      if (rspValid) begin
        if (expQ.size() == 0) begin
          check("R9 unexpected response", 32'(rspValid), 32'h0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check({e.tag, " loadData"}, loadData, e.ld);
          check({e.tag, " wrData"},   wrData,   e.wd);
          check({e.tag, " byteEn"},   32'(byteEn),   32'(e.en));
          check({e.tag, " misalign"}, 32'(misalign), 32'(e.mis));
        end
      end else begin
        check("R9 idle byteEn", 32'(byteEn), 32'h0);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        nRun++; nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", nRun, nFail);
        $finish;
      end
    join_none

    rstN = 1'b0; bigEndian = 0; reqValid = 0; reqStore = 0; reqByte = 0;
    reqOffset = 0; storeData = 0; memRdata = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rspValid", 32'(rspValid), 32'h0);
    check("R1 byteEn", 32'(byteEn), 32'h0);
    check("R1 loadData", loadData, 32'h0);
    check("R1 wrData", wrData, 32'h0);
    check("R1 misalign", 32'(misalign), 32'h0);
    rstN = 1'b1;

    // R2 / R3 / R4 byte loads over every offset, both endians, both signs
    for (int be = 0; be < 2; be++)
      for (int off = 0; off < 4; off++) begin
        drive(be[0], 0, 1, off[1:0], 32'h0, 32'h80_7F_C3_15,
              be ? "R3 R4 byte load" : "R2 R4 byte load");
        drive(be[0], 0, 1, off[1:0], 32'h0, 32'h11_A2_33_F4,
              be ? "R3 R4 byte load b" : "R2 R4 byte load b");
      end
    idle();
    // R6 byte stores over every offset
    for (int be = 0; be < 2; be++)
      for (int off = 0; off < 4; off++)
        drive(be[0], 1, 1, off[1:0], 32'hDEAD_BE9A, 32'h0,
              be ? "R6 R3 byte store" : "R6 R2 byte store");
    idle(); idle();
    // R5 / R7 aligned words
    drive(0, 0, 0, 2'd0, 32'h0, 32'hCAFE_F00D, "R5 word load le");
    drive(1, 0, 0, 2'd0, 32'h0, 32'h0123_4567, "R5 word load be");
    drive(0, 1, 0, 2'd0, 32'h8765_4321, 32'h0, "R7 word store le");
    drive(1, 1, 0, 2'd0, 32'hFFFF_0000, 32'h0, "R7 word store be");
    idle();
    // R8 misaligned words, R10 byte at same offsets
    for (int off = 1; off < 4; off++) begin
      drive(0, 1, 0, off[1:0], 32'h5555_AAAA, 32'h0, "R8 misaligned store");
      drive(1, 0, 0, off[1:0], 32'h0, 32'h9999_1111, "R8 misaligned load");
      drive(off[0], 1, 1, off[1:0], 32'h0000_0042, 32'h0, "R10 byte store");
    end
    // random mix
    for (int i = 0; i < 200; i++) begin
      if ($urandom_range(0, 3) == 0) idle();
      else drive(1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                 $urandom, $urandom, "R2 R3 R9 mixed");
    end
    idle(); idle(); idle();
    nRun++;
    if (expQ.size() != 0) begin
      nFail++;
      $display("FAIL R9 pending responses: actual %0d expected 0", expQ.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule